// File: doc/BRIEF.md
# Signal-Strength Capture Pacer

This block decides when a received-signal-strength measurement is taken and keeps the most recent result in a register for reading. A measurement is requested when either of two events occurs. One is a start-of-packet pulse. The other is a read of the result register. Because a read triggers a new measurement, a host that keeps polling the register while no packet is arriving sees a series of background-energy readings.

Requests are paced by a down-counter so that they never come closer together than a configured interval. The interval is 12 µs by default and is converted into clock cycles from a clock-frequency parameter. A trigger that lands inside the interval is not lost: it is remembered and served in the first cycle the interval allows.

The upstream measurement source receives a one-cycle request. It answers some cycles later with a sample and a valid flag. Only the first valid sample after a request is stored. A fresh flag tells the reader whether the stored value is new since its last read.

Top module: `sig_strength_capture`

## Requirements
- R1: After reset, `level_o` is 0, `fresh_o` is 0, `meas_req_o` is 0, and no request is issued until a trigger arrives.
- R2: A `pkt_start_i` pulse with the interval counter expired raises `meas_req_o` for exactly one cycle, in the cycle after the pulse.
- R3: A `rd_strobe_i` pulse with the interval counter expired raises `meas_req_o` for one cycle, in the cycle after the pulse.
- R4: `pkt_start_i` and `rd_strobe_i` high in the same cycle produce a single request.
- R5: Two `meas_req_o` pulses are never fewer than GAP_CYC cycles apart.
- R6: Triggers that arrive while the interval runs are merged into one pending request. That request is issued so that it lands exactly GAP_CYC cycles after the previous one.
- R7: `level_o` loads `smp_i` only when `smp_vld_i` is high and a request has been issued without a sample yet accepted for it. A valid sample at any other time leaves `level_o` and `fresh_o` unchanged.
- R8: A read never clears or alters `level_o`.
- R9: `fresh_o` goes to 1 in the cycle after a sample is accepted. It goes to 0 in the cycle after a read. When a sample is accepted in the same cycle as a read, `fresh_o` becomes 1.
- R10: GAP_CYC is the ceiling of CLK_HZ × GAP_NS / 10^9, with a minimum of 1. This is 144 at 12 MHz and 600 at 50 MHz with GAP_NS = 12000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start_i | input | 1 | Start-of-packet pulse |
| rd_strobe_i | input | 1 | One-cycle strobe for a completed read of the result register |
| smp_i | input | VAL_W | Raw strength sample from the measurement source |
| smp_vld_i | input | 1 | `smp_i` is valid this cycle |
| meas_req_o | output | 1 | One-cycle request for a new measurement |
| level_o | output | VAL_W | Stored strength value |
| fresh_o | output | 1 | Stored value not yet read |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the two trigger sources. A start-of-packet pulse and a read strobe are driven together, and the bench counts request pulses over the following interval; exactly one is expected.

The second pair is a sample acceptance and a read. A long upstream delay keeps a capture outstanding, and a forced valid sample is then driven together with the read strobe. The stored value must change and the fresh flag must end set.

Random stimulus keeps producing both overlaps, and also triggers that land inside the pacing interval. A cycle model derived from the requirements is compared against every output on every cycle.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    // Cycles needed to cover ns nanoseconds at hz, rounded up, never below one.
    function automatic int unsigned gap_cycles(input longint unsigned hz,
                                               input longint unsigned ns);
        longint unsigned c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return c[31:0];
    endfunction

endpackage

// File: rtl/ssc_pacer.sv
module ssc_pacer #(
    parameter int unsigned GAP_CYC = 144
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_i,
    input  logic rd_i,
    output logic req_o
);
    localparam int unsigned CW = $clog2(GAP_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
        logic          req;
    } pacer_t;

    pacer_t s_d, s_q;
    logic   trig;
    logic   issue;

    always_comb begin
        trig  = pkt_i | rd_i;
        issue = (trig | s_q.pend) && (s_q.cnt == '0);
        s_d   = s_q;
        s_d.req = issue;
        if (issue)
            s_d.cnt = CW'(GAP_CYC - 1);
        else if (s_q.cnt != '0)
            s_d.cnt = s_q.cnt - 1'b1;
        s_d.pend = (s_q.pend | trig) & ~issue;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_o = s_q.req;

    // Checker counter: cycles since the last request, saturating at GAP_CYC.
    logic [CW:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                         since_q <= (CW+1)'(GAP_CYC);
        else if (s_q.req)                   since_q <= (CW+1)'(1);
        else if (since_q < (CW+1)'(GAP_CYC)) since_q <= since_q + 1'b1;
    end

    p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (since_q >= (CW+1)'(GAP_CYC)));

    p_pend_serve_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && s_q.cnt == '0) |=> req_o);

    p_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pkt_i || rd_i) && s_q.cnt == '0) |=> req_o);

endmodule

// File: rtl/ssc_latch.sv
module ssc_latch #(
    parameter int unsigned VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             rd_i,
    input  logic [VAL_W-1:0] smp_i,
    input  logic             vld_i,
    output logic [VAL_W-1:0] level_o,
    output logic             fresh_o
);
    typedef struct packed {
        logic [VAL_W-1:0] level;
        logic             fresh;
        logic             armed;
    } hold_t;

    hold_t s_d, s_q;
    logic  take;

    always_comb begin
        take      = s_q.armed & vld_i;
        s_d       = s_q;
        s_d.armed = req_i | (s_q.armed & ~vld_i);
        if (take) begin
            s_d.level = smp_i;
            s_d.fresh = 1'b1;
        end else if (rd_i) begin
            s_d.fresh = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.level;
    assign fresh_o = s_q.fresh;

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.armed && vld_i) |=> $stable(level_o));

    p_fresh_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.armed && vld_i) |=> fresh_o);

    p_fresh_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !(s_q.armed && vld_i)) |=> !fresh_o);

endmodule

// File: rtl/sig_strength_capture.sv
module sig_strength_capture #(
    parameter int unsigned CLK_HZ = 12_000_000,
    parameter int unsigned GAP_NS = 12_000,
    parameter int unsigned VAL_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start_i,
    input  logic             rd_strobe_i,
    input  logic [VAL_W-1:0] smp_i,
    input  logic             smp_vld_i,
    output logic             meas_req_o,
    output logic [VAL_W-1:0] level_o,
    output logic             fresh_o
);
    localparam int unsigned GAP_CYC = ssc_pkg::gap_cycles(CLK_HZ, GAP_NS);

    logic req;

    ssc_pacer #(.GAP_CYC(GAP_CYC)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .pkt_i (pkt_start_i),
        .rd_i  (rd_strobe_i),
        .req_o (req)
    );

    ssc_latch #(.VAL_W(VAL_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .rd_i    (rd_strobe_i),
        .smp_i   (smp_i),
        .vld_i   (smp_vld_i),
        .level_o (level_o),
        .fresh_o (fresh_o)
    );

    assign meas_req_o = req;

    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req_o && GAP_CYC > 1) |=> !meas_req_o);

endmodule

// File: tb/tb_sig_strength_capture.sv
module tb_sig_strength_capture;
    localparam int unsigned HZ  = 50_000_000;
    localparam int unsigned NS  = 12_000;
    localparam int unsigned W   = 8;
    localparam int          GAP = 600;   // R10: ceil(50e6 * 12000 / 1e9)

    logic clk = 1'b0, rst_n = 1'b0, pkt = 1'b0, rd = 1'b0, vld = 1'b0;
    logic [W-1:0] smp = '0;
    logic req, fresh;
    logic [W-1:0] level;

    always #10 clk = ~clk;

    sig_strength_capture #(.CLK_HZ(HZ), .GAP_NS(NS), .VAL_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .pkt_start_i(pkt), .rd_strobe_i(rd),
        .smp_i(smp), .smp_vld_i(vld), .meas_req_o(req),
        .level_o(level), .fresh_o(fresh)
    );

    int errors = 0, checks = 0;

    // Cycle model built from the requirements.
    int m_cnt; bit m_pend, m_req, m_armed, m_fresh; logic [W-1:0] m_level;
    bit mt, mi, ml;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_pend <= 0; m_req <= 0; m_armed <= 0; m_fresh <= 0; m_level <= '0;
        end else begin
            mt = pkt | rd;
            mi = (mt | m_pend) && (m_cnt == 0);
            ml = m_armed & vld;
            m_cnt   <= mi ? GAP - 1 : (m_cnt > 0 ? m_cnt - 1 : 0);
            m_pend  <= (m_pend | mt) & ~mi;
            m_req   <= mi;
            m_armed <= m_req | (m_armed & ~vld);
            if (ml) begin m_level <= smp; m_fresh <= 1'b1; end
            else if (rd) m_fresh <= 1'b0;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    int resp_wait = 0, resp_min = 3, resp_span = 0;
    logic [W-1:0] resp_val = 8'h5A;
    int step_no = 0, last_req = -1;

    task automatic step(input bit p, input bit r, input bit fv, input logic [W-1:0] fval);
        chk("R6 request vs model", int'(req), int'(m_req));
        chk("R7 level vs model", int'(level), int'(m_level));
        chk("R9 fresh vs model", int'(fresh), int'(m_fresh));
        if (req) begin
            if (last_req >= 0) begin
                checks++;
                if (step_no - last_req < GAP) begin
                    errors++;
                    $display("FAIL R5 spacing: got %0d expected >= %0d", step_no - last_req, GAP);
                end
            end
            last_req = step_no;
        end
        step_no++;
        vld = 1'b0;
        if (req) resp_wait = resp_min + ((resp_span > 0) ? int'($urandom % resp_span) : 0);
        if (resp_wait == 1) begin
            vld = 1'b1; smp = resp_val; resp_val = W'($urandom);
        end
        if (resp_wait > 0) resp_wait--;
        if (fv) begin vld = 1'b1; smp = fval; end
        pkt = p; rd = r;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, '0);
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n, g;
        logic [W-1:0] lv;
        bit fl;
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 level", int'(level), 0);
        chk("R1 fresh", int'(fresh), 0);
        chk("R1 request", int'(req), 0);
        n = 0;
        for (int i = 0; i < GAP + 10; i++) begin step(0, 0, 0, '0); n += int'(req); end
        chk("R1 no pending", n, 0);

        // R2: packet start triggers a capture
        resp_val = 8'h5A;
        step(1, 0, 0, '0);
        chk("R2 request", int'(req), 1);
        idle(6);
        chk("R7 captured", int'(level), 'h5A);
        chk("R9 fresh set", int'(fresh), 1);
        idle(GAP);

        // R3, R8, R9: read
        step(0, 1, 0, '0);
        chk("R3 request", int'(req), 1);
        chk("R8 level kept", int'(level), 'h5A);
        chk("R9 fresh cleared", int'(fresh), 0);
        idle(GAP + 10);

        // R4: both triggers in one cycle
        step(1, 1, 0, '0);
        n = int'(req);
        for (int i = 0; i < GAP + 100; i++) begin step(0, 0, 0, '0); n += int'(req); end
        chk("R4 single request", n, 1);

        // R6, R10: triggers inside the interval
        step(1, 0, 0, '0);
        chk("R2 request again", int'(req), 1);
        g = 0;
        for (int i = 0; i < 10; i++) begin step(0, 0, 0, '0); g++; end
        step(0, 1, 0, '0); g++;
        for (int i = 0; i < 5; i++) begin step(0, 0, 0, '0); g++; end
        step(1, 0, 0, '0); g++;
        while (!req && g < 2000) begin step(0, 0, 0, '0); g++; end
        chk("R10 interval cycles", g, GAP);
        n = 0;
        for (int i = 0; i < GAP + 100; i++) begin step(0, 0, 0, '0); n += int'(req); end
        chk("R6 merged pending", n, 0);

        // R7: unsolicited valid sample ignored
        lv = level; fl = fresh;
        step(0, 0, 1, ~lv);
        chk("R7 ignored level", int'(level), int'(lv));
        chk("R7 ignored fresh", int'(fresh), int'(fl));

        // R9: sample accepted in the same cycle as a read
        resp_min = 100;
        step(1, 0, 0, '0);
        chk("R2 request for overlap", int'(req), 1);
        idle(2);
        step(0, 1, 1, 8'hC3);
        chk("R9 take wins over read", int'(fresh), 1);
        chk("R7 overlap value", int'(level), 'hC3);
        resp_min = 1; resp_span = 40;

        // Random traffic
        for (int i = 0; i < 20000; i++)
            step(($urandom % 200) == 0, ($urandom % 150) == 0,
                 ($urandom % 300) == 0, W'($urandom));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule